// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block watches the position outputs of a raster counter (line, dot within the line, and the field parity) and produces three single-cycle interrupt pulses at positions set by software. Two vertical interrupts fire when the raster reaches the first dot of a chosen line. A third, horizontal interrupt fires at a chosen dot of a chosen line. It can fire once per frame, every N field lines, or on every field line.

Line numbers written to the block count field lines. A programmed value L refers to raster line 2L in the even field and to raster line 2L+1 in the odd field. The block has a simple write port with a select bit that picks one of its two registers. It does not aggregate or clear interrupts; a downstream controller latches the pulses.

The horizontal interrupt is built around a three-state machine:
- HS_ONCE matches the line field of the register directly.
- HS_WRAP folds the running target back into the field, subtracting half the total line count once per clock.
- HS_TRACK matches the running target.

The transitions are:
- A write with a repeating mode moves any state to HS_WRAP.
- A write with a frame mode moves any state to HS_ONCE.
- HS_WRAP stays in HS_WRAP while the target is not below half the total, then moves to HS_TRACK.
- HS_TRACK moves to HS_WRAP on each firing, after adding the stride to the target.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset all three outputs are low and both registers read as zero. A horizontal register of zero is frame mode, line 0, dot 0, so the first dot of raster line 0 in the even field raises all three pulses.
- R2: A write with `wr_sel`=0 loads vertical line A from bits 25:16 and vertical line B from bits 9:0. All other bits are ignored.
- R3: Vertical line L fires its output for exactly one clock, in the clock after an edge where `dot_en`=1, `dot`=0 and `line` equals 2L plus `field_odd`.
- R4: A vertical or horizontal target whose doubled value is not below `total_lines` never fires.
- R5: No output pulses after an edge where `dot_en` is low.
- R6: A write with `wr_sel`=1 loads the count or line from bits 9:0, the mode from bits 13:12 and the dot position from bits 25:16. Bits 15:14, 11:10 and 31:26 are ignored.
- R7: Mode 0, and the reserved mode 3 treated as mode 0, fire once per field at raster line 2L plus `field_odd`, at dot twice the dot field.
- R8: If twice the dot field is not below `line_len`, the horizontal pulse falls on dot `line_len`-1.
- R9: On a write of mode 1 or 2, the first target field line is the current field line (`line`>>1) plus the stride, reduced modulo half of `total_lines`.
- R10: In modes 1 and 2, each horizontal firing advances the target by the stride, modulo half of `total_lines`.
- R11: Mode 2 uses a stride of 1 whatever bits 9:0 hold.
- R12: Mode 1 with a count of 0 uses a stride of 1.
- R13: On the edge that writes the horizontal register, the horizontal output stays low. The vertical outputs are unaffected by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Raster position is valid and advancing this cycle |
| line | input | LINE_W | Current raster line |
| dot | input | DOT_W | Current dot within the line |
| field_odd | input | 1 | 1 in the odd field |
| total_lines | input | LINE_W+1 | Raster lines per frame |
| line_len | input | DOT_W | Dots per line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the vertical register, 1 the horizontal |
| wr_data | input | 32 | Write data |
| irq_vpos1 | output | 1 | Pulse for vertical line A |
| irq_vpos2 | output | 1 | Pulse for vertical line B |
| irq_hpos | output | 1 | Pulse for the horizontal position |

## Verification
The collision of interest is a horizontal-register write landing on the very edge where the old horizontal target would match. The bench holds back a write until the raster sits at the matching line and dot with `dot_en` high, in the even field. The scoreboard then expects that edge to give no horizontal pulse. A second coincidence is a vertical and a horizontal pulse in the same cycle, provoked by an every-line mode at dot 0; the scoreboard checks that both outputs rise together.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    localparam int FIELD_W = 10;

    // Field positions within the two write words.
    localparam int VA_LSB   = 16;
    localparam int VB_LSB   = 0;
    localparam int HCNT_LSB = 0;
    localparam int HMOD_LSB = 12;
    localparam int HDOT_LSB = 16;

    typedef enum logic [1:0] {
        HM_FRAME  = 2'd0,
        HM_NLINES = 2'd1,
        HM_EVERY  = 2'd2,
        HM_RSVD   = 2'd3
    } hmode_e;

    typedef enum logic [1:0] {
        HS_ONCE  = 2'd0,
        HS_WRAP  = 2'd1,
        HS_TRACK = 2'd2
    } hstate_e;

    typedef struct packed {
        logic [FIELD_W-1:0] dot_pos;
        hmode_e             mode;
        logic [FIELD_W-1:0] count;
    } hcfg_t;

endpackage

// File: rtl/rirq_regs.sv
module rirq_regs
    import raster_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [1:0][FIELD_W-1:0]      vline,
    output logic                         h_wr,
    output hcfg_t                        h_new
);

    logic v_wr;

    assign v_wr = wr_en && !wr_sel;
    assign h_wr = wr_en && wr_sel;

    always_comb begin
        h_new.count   = wr_data[HCNT_LSB +: FIELD_W];
        h_new.mode    = hmode_e'(wr_data[HMOD_LSB +: 2]);
        h_new.dot_pos = wr_data[HDOT_LSB +: FIELD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vline <= '0;
        end else if (v_wr) begin
            vline[0] <= wr_data[VA_LSB +: FIELD_W];
            vline[1] <= wr_data[VB_LSB +: FIELD_W];
        end
    end

    // R2: each vertical line lands from its own field
    a_r2_line_a_field: assert property (@(posedge clk) disable iff (!rst_n)
        v_wr |=> vline[0] == $past(wr_data[VA_LSB +: FIELD_W]));
    a_r2_line_b_field: assert property (@(posedge clk) disable iff (!rst_n)
        v_wr |=> vline[1] == $past(wr_data[VB_LSB +: FIELD_W]));

endmodule

// File: rtl/rirq_vmatch.sv
module rirq_vmatch
    import raster_irq_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int DOT_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dot_en,
    input  logic [LINE_W-1:0]  line,
    input  logic [DOT_W-1:0]   dot,
    input  logic               field_odd,
    input  logic [LINE_W:0]    total_lines,
    input  logic [FIELD_W-1:0] target,
    output logic               irq
);

    localparam int CW = ((LINE_W > FIELD_W) ? LINE_W : FIELD_W) + 2;

    logic [CW-1:0] want_row, have_row, dbl_row, tot_x;
    logic          hit;

    assign want_row = CW'({target, field_odd});
    assign have_row = CW'(line);
    assign dbl_row  = CW'({target, 1'b0});
    assign tot_x    = CW'(total_lines);

    assign hit = dot_en && (dot == '0) && (want_row == have_row) && (dbl_row < tot_x);

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

    a_r5_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> !irq);
    a_r3_start_of_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(dot) == '0);
    a_r4_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (CW'({$past(target), 1'b0}) < CW'($past(total_lines))));

endmodule

// File: rtl/rirq_hsched.sv
module rirq_hsched
    import raster_irq_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int DOT_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dot_en,
    input  logic [LINE_W-1:0]  line,
    input  logic [DOT_W-1:0]   dot,
    input  logic               field_odd,
    input  logic [LINE_W:0]    total_lines,
    input  logic [DOT_W-1:0]   line_len,
    input  logic               cfg_wr,
    input  hcfg_t              cfg_new,
    output logic               irq
);

    localparam int TW = FIELD_W + 1;
    localparam int CW = ((LINE_W > FIELD_W) ? LINE_W : FIELD_W) + 2;
    localparam int EW = ((DOT_W > FIELD_W + 1) ? DOT_W : FIELD_W + 1) + 1;

    hcfg_t         cfg;
    hstate_e       st, st_nxt;
    logic [TW-1:0] tgt, half, row;
    logic [CW-1:0] want_row, have_row, dbl_row, tot_x;
    logic [EW-1:0] dot_dbl, len_x, dot_goal, dot_x;
    logic          fire, over;

    function automatic logic [TW-1:0] stride(input hcfg_t c);
        if (c.mode == HM_EVERY || c.count == '0) return TW'(1);
        return TW'(c.count);
    endfunction

    function automatic logic repeats(input hmode_e m);
        return (m == HM_NLINES) || (m == HM_EVERY);
    endfunction

    assign half = TW'(total_lines >> 1);
    assign over = (half != '0) && (tgt >= half);
    assign row  = (st == HS_ONCE) ? TW'(cfg.count) : tgt;

    assign want_row = CW'({row, field_odd});
    assign have_row = CW'(line);
    assign dbl_row  = CW'({row, 1'b0});
    assign tot_x    = CW'(total_lines);

    assign dot_dbl  = EW'({cfg.dot_pos, 1'b0});
    assign len_x    = EW'(line_len);
    assign dot_goal = (dot_dbl >= len_x) ? (len_x - EW'(1)) : dot_dbl;
    assign dot_x    = EW'(dot);

    assign fire = dot_en && !cfg_wr && (st != HS_WRAP) && (dot_x == dot_goal)
               && (want_row == have_row) && (dbl_row < tot_x);

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            HS_ONCE:  st_nxt = HS_ONCE;
            HS_WRAP:  if (!over) st_nxt = HS_TRACK;
            HS_TRACK: if (fire) st_nxt = HS_WRAP;
            default:  st_nxt = HS_ONCE;
        endcase
        if (cfg_wr) st_nxt = repeats(cfg_new.mode) ? HS_WRAP : HS_ONCE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= HS_ONCE;
        else        st <= st_nxt;
    end

    // configuration, running target and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            tgt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= fire;
            if (cfg_wr) begin
                cfg <= cfg_new;
                tgt <= TW'(line >> 1) + stride(cfg_new);
            end else if (st == HS_WRAP && over) begin
                tgt <= tgt - half;
            end else if (st == HS_TRACK && fire) begin
                tgt <= tgt + stride(cfg);
            end
        end
    end

    a_r13_write_silences: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !irq);
    a_r5_h_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> !irq);
    a_r8_dot_within_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (EW'($past(dot)) < EW'($past(line_len))));

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import raster_irq_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int DOT_W  = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    input  logic              field_odd,
    input  logic [LINE_W:0]   total_lines,
    input  logic [DOT_W-1:0]  line_len,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_vpos1,
    output logic              irq_vpos2,
    output logic              irq_hpos
);

    localparam int NV = 2;

    logic [NV-1:0][FIELD_W-1:0] vline;
    logic [NV-1:0]              virq;
    logic                       h_wr;
    hcfg_t                      h_new;

    rirq_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vline(vline), .h_wr(h_wr), .h_new(h_new)
    );

    for (genvar gi = 0; gi < NV; gi++) begin : g_vert
        rirq_vmatch #(.LINE_W(LINE_W), .DOT_W(DOT_W)) vm_i (
            .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line(line), .dot(dot),
            .field_odd(field_odd), .total_lines(total_lines),
            .target(vline[gi]), .irq(virq[gi])
        );
    end

    rirq_hsched #(.LINE_W(LINE_W), .DOT_W(DOT_W)) hs_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line(line), .dot(dot),
        .field_odd(field_odd), .total_lines(total_lines), .line_len(line_len),
        .cfg_wr(h_wr), .cfg_new(h_new), .irq(irq_hpos)
    );

    assign irq_vpos1 = virq[0];
    assign irq_vpos2 = virq[1];

endmodule

// File: tb/raster_irq_gen_tb.sv
module raster_irq_gen_tb_top;

    localparam int LW = 10;
    localparam int DW = 11;
    localparam int TL = 20;
    localparam int LL = 16;
    localparam int FR = LL * TL * 3 / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dot_en = 1'b0;
    logic [LW-1:0] line = '0;
    logic [DW-1:0] dot = '0;
    logic          field_odd = 1'b0;
    logic [LW:0]   total_lines = (LW+1)'(TL);
    logic [DW-1:0] line_len = DW'(LL);
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          irq_v1, irq_v2, irq_h;

    always #5 clk = ~clk;

    raster_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line(line), .dot(dot),
        .field_odd(field_odd), .total_lines(total_lines), .line_len(line_len),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_vpos1(irq_v1), .irq_vpos2(irq_v2), .irq_hpos(irq_h)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [2:0] exp_q[$];
    string      tv_q[$];
    string      th_q[$];
    bit         forced_q[$];

    bit          req_pend = 0, req_sel = 0, req_cond = 0;
    logic [31:0] req_data = '0;
    int          req_line = 0, req_dot = 0;

    string stage_v = "R1";
    string stage_h = "R1";

    int mv1 = 0, mv2 = 0, mcount = 0, mmode = 0, mdotp = 0, mtgt = 0;
    bit h_fired = 0;

    int r_line = 0, r_dot = 0, cyc = 0;
    bit r_odd = 0, last_en = 0, started = 0, finished = 0;

    function automatic int wrapf(int t);
        while (t >= TL / 2) t -= TL / 2;
        return t;
    endfunction

    function automatic int stridef(int mode, int cnt);
        return (mode == 2 || cnt == 0) ? 1 : cnt;
    endfunction

    task automatic check(string tag, logic got, logic expv, string what);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, got, expv);
        end
    endtask

    // monitor: pops one expectation per cycle
    task automatic monitor_pop();
        logic [2:0] e;
        string tv, th;
        bit f;
        e  = exp_q.pop_front();
        tv = tv_q.pop_front();
        th = th_q.pop_front();
        f  = forced_q.pop_front();
        if (f || e != 3'b000 || {irq_v1, irq_v2, irq_h} != 3'b000) begin
            check(tv, irq_v1, e[2], "vpos1");
            check(tv, irq_v2, e[1], "vpos2");
            check(th, irq_h,  e[0], "hpos");
        end
    endtask

    // driver: advances the raster, applies writes, pushes expectations
    task automatic drive_push();
        bit en, do_wr, ev1, ev2, eh, forced;
        int row, goal;
        string tv, th;
        if (last_en) begin
            r_dot++;
            if (r_dot == LL) begin
                r_dot = 0;
                r_line++;
                if (r_line == TL) begin
                    r_line = 0;
                    r_odd = !r_odd;
                end
            end
        end
        en = (cyc % 3) != 2;
        cyc++;
        do_wr = req_pend && (!req_cond ||
                 (en && !r_odd && r_line == req_line && r_dot == req_dot));
        dot_en    = en;
        line      = LW'(r_line);
        dot       = DW'(r_dot);
        field_odd = r_odd;
        wr_en     = do_wr;
        wr_sel    = req_sel;
        wr_data   = req_data;

        ev1 = en && r_dot == 0 && r_line == 2*mv1 + r_odd && 2*mv1 < TL;
        ev2 = en && r_dot == 0 && r_line == 2*mv2 + r_odd && 2*mv2 < TL;
        row  = (mmode == 1 || mmode == 2) ? mtgt : mcount;
        goal = (2*mdotp >= LL) ? LL - 1 : 2*mdotp;
        eh = en && !(do_wr && req_sel) && r_dot == goal
             && r_line == 2*row + r_odd && 2*row < TL;

        forced = !en || (do_wr && req_sel);
        tv = !en ? "R5" : stage_v;
        if (!en)                              th = "R5";
        else if (do_wr && req_sel)            th = "R13";
        else if (stage_h == "R9" && h_fired)  th = "R10";
        else                                  th = stage_h;

        if (eh) begin
            h_fired = 1;
            if (mmode == 1 || mmode == 2) mtgt = wrapf(mtgt + stridef(mmode, mcount));
        end

        if (do_wr) begin
            req_pend = 0;
            if (!req_sel) begin
                mv1 = int'(req_data[25:16]);
                mv2 = int'(req_data[9:0]);
            end else begin
                mcount  = int'(req_data[9:0]);
                mmode   = int'(req_data[13:12]);
                mdotp   = int'(req_data[25:16]);
                h_fired = 0;
                if (mmode == 1 || mmode == 2)
                    mtgt = wrapf(r_line / 2 + stridef(mmode, mcount));
            end
        end

        exp_q.push_back({ev1, ev2, eh});
        tv_q.push_back(tv);
        th_q.push_back(th);
        forced_q.push_back(forced);
        last_en = en;
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (started) monitor_pop();
            drive_push();
            started = 1;
        end
    end

    task automatic post(bit sel, logic [31:0] d, bit cond = 0, int ln = 0, int dt = 0);
        @(posedge clk);
        req_sel  = sel;
        req_data = d;
        req_cond = cond;
        req_line = ln;
        req_dot  = dt;
        req_pend = 1;
        while (req_pend) @(posedge clk);
    endtask

    task automatic run_frames(int n);
        repeat (n * FR) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", irq_v1, 1'b0, "vpos1 in reset");
        check("R1", irq_v2, 1'b0, "vpos2 in reset");
        check("R1", irq_h,  1'b0, "hpos in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        run_frames(2);
        // vertical: garbage bits, line B suppressed (24 >= 20)
        stage_v = "R2";
        post(0, 32'hFC00_FC00 | (32'd9 << 16) | 32'd12);
        run_frames(2);
        stage_v = "R3";
        post(0, (32'd3 << 16) | 32'd7);
        run_frames(2);
        // R4 boundary: line A of 10 doubles to exactly the total
        stage_v = "R4";
        post(0, (32'd10 << 16) | 32'd9);
        run_frames(2);
        stage_h = "R6";
        post(1, 32'hFC00_CC00 | (32'd5 << 16) | 32'd4);
        run_frames(2);
        stage_h = "R7";
        post(1, 32'h0002_3006);
        run_frames(2);
        // R8 boundary: doubled dot equals the line length
        stage_h = "R8";
        post(1, (32'd8 << 16) | 32'd2);
        run_frames(2);
        stage_h = "R9";
        post(1, 32'h0003_100D);
        run_frames(3);
        stage_h = "R11";
        post(1, 32'h0001_2005);
        run_frames(2);
        // R12: every field line at dot 0, meets the vertical pulses
        stage_h = "R12";
        post(1, 32'h0000_1000);
        run_frames(2);
        stage_h = "R13";
        post(1, 32'h0003_0004);
        run_frames(1);
        post(1, 32'h0003_0004, 1, 8, 6);
        run_frames(1);
        @(posedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule